// File: doc/BRIEF.md
# Sub-Source Interrupt Pending Combiner

This block holds the second level of a two-level interrupt pending scheme. Individual interrupt causes, the sub-sources, are caught in a 15-bit sub-pending register. A 15-bit sub-mask register sits beside it. Every unmasked pending sub-source is then folded into one bit of a small main-pending register, one bit per peripheral. The main-level priority logic reads that register.

The sub-sources fall into these groups:
- Three UART channels. Each channel owns three adjacent sub-source bits: receive, transmit and error.
- One ADC group of two bits.
- Four spare bits at the top. They can be latched and masked, but they feed no main bit.

Peripherals raise a sub-source with a one-cycle event pulse. Software uses a small register bus to read the registers, clear bits by writing 1 to them, set sub-sources, and load the mask.

Top module: `irq_subsrc_combiner`

## Requirements
- R1: After reset the sub-pending register reads 0, the main-pending output is 0, and the sub-mask register reads 0x7FFF (every sub-source masked).
- R2: A 1 on sub_evt_i[k] in a cycle sets sub-pending bit k at that clock edge. The bit then stays set until it is cleared.
- R3: A bus write to address 0 (sub-pending) clears every bit written as 1 and leaves every bit written as 0 unchanged. If an event or a set arrives for the same bit in the same cycle, the set wins and the bit stays 1.
- R4: A bus write to address 3 (sub-set) sets every sub-pending bit written as 1. Reads from address 3 return 0.
- R5: A bus write to address 1 loads the sub-mask register, and address 1 reads it back. A sub-source requests only when its pending bit is 1 and its mask bit is 0.
- R6: UART channel c owns sub-source bits 3c (receive), 3c+1 (transmit) and 3c+2 (error). Any requesting bit in that group sets main_pend_o[c] one clock after the request is visible. This holds for c = 0, 1 and 2.
- R7: Any requesting sub-source in bits 10:9 sets main_pend_o[3] (the ADC bit) one clock after the request is visible.
- R8: Sub-source bits 14:11 latch and mask like any other bit, but they never change main_pend_o.
- R9: Main-pending bits are sticky. Clearing or masking the sub-sources behind a main bit does not clear that main bit.
- R10: A bus write to address 2 clears every main-pending bit written as 1, and a bit written as 0 is unchanged. If the group behind a cleared bit is still requesting, the bit is 0 for one cycle and sets again at the next edge. Address 2 reads the main-pending register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sub_evt_i | input | 15 | One-cycle event pulse for each sub-source |
| bus_we_i | input | 1 | Bus write strobe |
| bus_addr_i | input | 2 | Register select: 0 sub-pending, 1 sub-mask, 2 main-pending, 3 sub-set |
| bus_wdata_i | input | 15 | Bus write data |
| bus_rdata_o | output | 15 | Bus read data for the selected register (combinational) |
| main_pend_o | output | 4 | Main-pending bits: bit 0 UART0, bit 1 UART1, bit 2 UART2, bit 3 ADC |

## Verification
Two pairs of functions can meet in one cycle, and both pairs are provoked on purpose.

The first pair is an event pulse and a write-1-to-clear on the sub-pending register. The bench drives an event on bit 5 in the same cycle as a clear that covers bits 5 and 12. It then expects bit 12 to be gone and bit 5 to have survived.

The second pair is a main-pending clear and a group that is still requesting. The bench clears the UART1 main bit while its transmit sub-source is still pending and unmasked. It expects the bit to read 0 for exactly one cycle and to be 1 again on the next cycle.

A behavioural model built from R1 to R10 judges both collisions. Every clock it is compared with main_pend_o and with the read data at the current address.

// File: rtl/irq_comb_pkg.sv
package irq_comb_pkg;
  localparam int unsigned SUBS_PER_CH = 3;
  localparam int unsigned OFS_RX  = 0;
  localparam int unsigned OFS_TX  = 1;
  localparam int unsigned OFS_ERR = 2;

  typedef enum logic [1:0] {
    SEL_SUB_PEND = 2'd0,
    SEL_SUB_MASK = 2'd1,
    SEL_MAIN     = 2'd2,
    SEL_SUB_SET  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/pend_reg.sv
// Generic set/clear pending register. SET_WINS picks the collision rule.
module pend_reg #(
  parameter int unsigned W        = 15,
  parameter bit          SET_WINS = 1'b1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_d, q_q;

  generate
    if (SET_WINS) begin : g_set_wins
      assign q_d = (q_q & ~clr_i) | set_i;

      assert_set_lands_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> ((q_q & $past(set_i)) == $past(set_i)));
      assert_clear_applies_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> ((q_q & $past(clr_i & ~set_i)) == '0));
    end else begin : g_clr_wins
      assign q_d = (q_q | set_i) & ~clr_i;

      assert_req_lands_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> ((q_q & $past(set_i & ~clr_i)) == $past(set_i & ~clr_i)));
      assert_clear_applies_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> ((q_q & $past(clr_i)) == '0));
      assert_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((~q_q & $past(q_q) & ~$past(clr_i)) == '0));
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_q <= '0;
    else         q_q <= q_d;
  end

  assign q_o = q_q;
endmodule

// File: rtl/mask_reg.sv
module mask_reg #(
  parameter int unsigned W = 15
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_q <= '1;
    else if (load_i) q_q <= data_i;
  end

  assign q_o = q_q;
endmodule

// File: rtl/group_fold.sv
// Collapses requesting sub-sources into one request per peripheral.
module group_fold #(
  parameter int unsigned NUM_UART = 3,
  parameter int unsigned ADC_W    = 2,
  localparam int unsigned ADC_BASE = NUM_UART * irq_comb_pkg::SUBS_PER_CH,
  localparam int unsigned SPAN     = ADC_BASE + ADC_W,
  localparam int unsigned MAIN_W   = NUM_UART + 1
) (
  input  logic [SPAN-1:0]   req_i,
  output logic [MAIN_W-1:0] grp_o
);
  import irq_comb_pkg::*;

  generate
    for (genvar c = 0; c < NUM_UART; c++) begin : g_uart
      assign grp_o[c] = |req_i[c*SUBS_PER_CH +: SUBS_PER_CH];
    end
  endgenerate

  assign grp_o[NUM_UART] = |req_i[ADC_BASE +: ADC_W];
endmodule

// File: rtl/irq_subsrc_combiner.sv
module irq_subsrc_combiner #(
  parameter int unsigned NUM_UART = 3,
  parameter int unsigned ADC_W    = 2,
  parameter int unsigned SUB_W    = 15,
  localparam int unsigned ADC_BASE = NUM_UART * irq_comb_pkg::SUBS_PER_CH,
  localparam int unsigned SPAN     = ADC_BASE + ADC_W,
  localparam int unsigned MAIN_W   = NUM_UART + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [SUB_W-1:0]  sub_evt_i,
  input  logic              bus_we_i,
  input  logic [1:0]        bus_addr_i,
  input  logic [SUB_W-1:0]  bus_wdata_i,
  output logic [SUB_W-1:0]  bus_rdata_o,
  output logic [MAIN_W-1:0] main_pend_o
);
  import irq_comb_pkg::*;

  reg_sel_e            sel;
  logic [SUB_W-1:0]    sub_q, mask_q, sub_set, sub_clr;
  logic [MAIN_W-1:0]   main_q, main_clr, grp_req;
  logic [SPAN-1:0]     req_span;

  assign sel = reg_sel_e'(bus_addr_i);

  always_comb begin
    sub_set  = sub_evt_i;
    sub_clr  = '0;
    main_clr = '0;
    if (bus_we_i) begin
      unique case (sel)
        SEL_SUB_PEND: sub_clr  = bus_wdata_i;
        SEL_SUB_SET:  sub_set  = sub_evt_i | bus_wdata_i;
        SEL_MAIN:     main_clr = bus_wdata_i[MAIN_W-1:0];
        default: ;
      endcase
    end
  end

  pend_reg #(.W(SUB_W), .SET_WINS(1'b1)) u_sub_pend (
    .clk_i (clk_i), .rst_ni(rst_ni),
    .set_i (sub_set), .clr_i(sub_clr), .q_o(sub_q)
  );

  mask_reg #(.W(SUB_W)) u_sub_mask (
    .clk_i (clk_i), .rst_ni(rst_ni),
    .load_i(bus_we_i && sel == SEL_SUB_MASK),
    .data_i(bus_wdata_i), .q_o(mask_q)
  );

  assign req_span = sub_q[SPAN-1:0] & ~mask_q[SPAN-1:0];

  group_fold #(.NUM_UART(NUM_UART), .ADC_W(ADC_W)) u_fold (
    .req_i(req_span), .grp_o(grp_req)
  );

  pend_reg #(.W(MAIN_W), .SET_WINS(1'b0)) u_main_pend (
    .clk_i (clk_i), .rst_ni(rst_ni),
    .set_i (grp_req), .clr_i(main_clr), .q_o(main_q)
  );

  always_comb begin
    unique case (sel)
      SEL_SUB_PEND: bus_rdata_o = sub_q;
      SEL_SUB_MASK: bus_rdata_o = mask_q;
      SEL_MAIN:     bus_rdata_o = SUB_W'(main_q);
      default:      bus_rdata_o = '0;
    endcase
  end

  assign main_pend_o = main_q;

  // A masked group must not raise its main bit
  assert_masked_group_quiet_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((mask_q[2:0] == 3'b111) && !main_q[0] && main_clr[0] == 1'b0) |=> !main_q[0]);
endmodule

// File: tb/irq_subsrc_combiner_bench.sv
module irq_subsrc_combiner_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [14:0] evt = '0;
  logic        we = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [14:0] wdata = '0;
  logic [14:0] rdata;
  logic [3:0]  main_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit compare_on = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_subsrc_combiner u_irq_subsrc_combiner (
    .clk_i(clk), .rst_ni(rst_n), .sub_evt_i(evt), .bus_we_i(we),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .main_pend_o(main_o)
  );

  // Behavioural reference model
  logic [14:0] m_sub, m_mask;
  logic [3:0]  m_main;

  function automatic logic [3:0] fold(input logic [14:0] r);
    logic [3:0] g;
    g[0] = r[0] | r[1] | r[2];
    g[1] = r[3] | r[4] | r[5];
    g[2] = r[6] | r[7] | r[8];
    g[3] = r[9] | r[10];
    return g;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_sub <= '0; m_mask <= 15'h7fff; m_main <= '0;
    end else begin
      logic [14:0] s_clr, s_set;
      logic [3:0]  mc;
      s_clr = (we && addr == 2'd0) ? wdata : 15'h0;
      s_set = evt | ((we && addr == 2'd3) ? wdata : 15'h0);
      mc    = (we && addr == 2'd2) ? wdata[3:0] : 4'h0;
      m_main <= (m_main | fold(m_sub & ~m_mask)) & ~mc;
      m_sub  <= (m_sub & ~s_clr) | s_set;
      if (we && addr == 2'd1) m_mask <= wdata;
    end
  end

  function automatic logic [14:0] m_read(input logic [1:0] a);
    case (a)
      2'd0: return m_sub;
      2'd1: return m_mask;
      2'd2: return {11'h0, m_main};
      default: return 15'h0;
    endcase
  endfunction

  task automatic check(input string tag, input logic [14:0] act, input logic [14:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (compare_on && rst_n) begin
      check("MODEL main (R6 R7 R9 R10)", {11'h0, main_o}, {11'h0, m_main});
      check("MODEL read (R3 R4 R5)", rdata, m_read(addr));
    end
  end

  task automatic wr(input logic [1:0] a, input logic [14:0] d);
    @(posedge clk); #1;
    we = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1;
    we = 1'b0; wdata = '0;
  endtask

  task automatic pulse(input int k);
    @(posedge clk); #1;
    evt = 15'h0; evt[k] = 1'b1;
    @(posedge clk); #1;
    evt = '0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #1;
  endtask

  task automatic rd_check(input string tag, input logic [1:0] a, input logic [14:0] exp);
    addr = a;
    @(negedge clk);
    check(tag, rdata, exp);
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 20000);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 3);
    rst_n = 1'b1;
    #1;
    compare_on = 1'b1;
    rd_check("R1 sub pending reset", 2'd0, 15'h0000);
    rd_check("R1 mask reset", 2'd1, 15'h7fff);
    check("R1 main reset", {11'h0, main_o}, 15'h0);

    wr(2'd1, 15'h0000);
    pulse(4);                       // UART1 transmit
    idle(1);
    rd_check("R2 event latched", 2'd0, 15'h0010);
    check("R6 uart1 main bit", {11'h0, main_o}, 15'h0002);

    wr(2'd2, 15'h0002);             // clear while still requesting
    @(negedge clk);
    check("R10 main cleared for one cycle", {11'h0, main_o}, 15'h0000);
    @(negedge clk);
    check("R10 main re-set by live group", {11'h0, main_o}, 15'h0002);

    wr(2'd0, 15'h0010);
    idle(2);
    rd_check("R3 sub cleared by write-1", 2'd0, 15'h0000);
    check("R9 main sticky after sub clear", {11'h0, main_o}, 15'h0002);
    wr(2'd2, 15'h0002);
    idle(2);
    check("R10 main cleared, no request", {11'h0, main_o}, 15'h0000);

    wr(2'd1, 15'h0001);             // mask UART0 receive
    pulse(0);
    idle(3);
    rd_check("R5 mask readback", 2'd1, 15'h0001);
    check("R5 masked source no main", {11'h0, main_o}, 15'h0000);
    wr(2'd1, 15'h0000);
    idle(1);
    check("R6 uart0 after unmask", {11'h0, main_o}, 15'h0001);

    pulse(12);
    idle(2);
    rd_check("R8 spare bit latched", 2'd0, 15'h1001);
    check("R8 spare bit no main", {11'h0, main_o}, 15'h0001);

    pulse(10);
    idle(1);
    check("R7 adc main bit", {11'h0, main_o}, 15'h0009);

    wr(2'd3, 15'h0100);
    idle(1);
    check("R4 set via bus, uart2", {11'h0, main_o}, 15'h000d);
    rd_check("R4 set address reads 0", 2'd3, 15'h0000);

    // clear and event collide on bit 5; bit 12 cleared
    @(posedge clk); #1;
    we = 1'b1; addr = 2'd0; wdata = 15'h1020; evt = 15'h0020;
    @(posedge clk); #1;
    we = 1'b0; wdata = '0; evt = '0;
    idle(1);
    rd_check("R3 event wins over clear", 2'd0, 15'h0521);
    check("R6 uart1 from collided bit", {11'h0, main_o}, 15'h000f);

    wr(2'd2, 15'h0000);
    idle(1);
    check("R10 write 0 no effect", {11'h0, main_o}, 15'h000f);

    wr(2'd1, 15'h7fff);
    idle(2);
    check("R9 sticky after masking", {11'h0, main_o}, 15'h000f);
    wr(2'd2, 15'h000f);
    idle(2);
    check("R10 clear all, groups masked", {11'h0, main_o}, 15'h0000);
    rd_check("R2 sub bits persist", 2'd0, 15'h0521);

    idle(2);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule